// File: doc/BRIEF.md
# Three-Tick Synchronous Read Slave

This block sits on the memory side of a shared-clock bus and answers read requests with a fixed three-tick pacing instead of a handshake. During the first tick the requester holds an address steady and raises its read line. The slave spends the second tick on the internal lookup. In the third tick it drives the word onto the data lines so that the requester can capture it. Every bus input is sensed on the trailing (falling) clock edge. The slave's registers also change on that edge, so each value is steady around the rising edge.

A small word array holds the contents. A plain write strobe lets the surrounding environment preload locations between transfers. Reads never alter what is stored.

Top module: `tick_read_slave`

## Requirements
- R1: While idle, a high `rd_req` sensed on a falling edge starts a transfer, and `addr` is captured on that same edge; later changes to `addr` do not affect the returned word.
- R2: For the whole tick after the accepting edge (the access tick), `data_oe` is 0 and `rd_data` is 0.
- R3: For exactly one tick after the access tick (the drive tick), `data_oe` is 1 and `rd_data` carries the word stored at the captured address.
- R4: Whenever `data_oe` is 0, `rd_data` is all zeros.
- R5: `rd_req` sensed during the access or drive tick is ignored; the slave returns to idle after the drive tick and starts no transfer unless `rd_req` is high on a later falling edge.
- R6: A read leaves the stored word unchanged, so repeated reads return the same value.
- R7: While idle with `rd_req` low, a high `wr_en` on a falling edge copies `wr_data` into the location at `addr`.
- R8: `wr_en` is ignored during the access and drive ticks, and also when `rd_req` is high on the same edge, where the read takes priority.
- R9: Locations are selected by the low log2(DEPTH) bits of `addr`; higher bits are ignored (with DEPTH 64, addresses 0x0045 and 0x1005 both select location 5).
- R10: After reset `data_oe` is 0, the slave is idle, and every location reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock; inputs are sensed on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Address for reads and writes |
| rd_req | input | 1 | Memory-read indication from the requester |
| wr_en | input | 1 | Preload write strobe |
| wr_data | input | 16 | Word to store on a write |
| rd_data | output | 16 | Data lines; zero when released |
| data_oe | output | 1 | High only while the slave drives the data lines |

## Verification
A table of preload words, covering both ends of the array and mixed bit patterns, is written and then read back one tick-sequence at a time. This confirms the access-tick silence and the drive-tick word for each address. Directed sequences then hold `rd_req` high into the access and drive ticks, move `addr` after acceptance, and pulse `wr_en` while busy or together with a read. These show whether the sequencer re-triggers, latches the address late, or lets a write slip through. Aliased addresses that differ only in high bits show whether the decode uses the index bits alone, and a read straight after reset shows whether the array is cleared.

// File: rtl/rdslv_pkg.sv
package rdslv_pkg;

  typedef enum logic [1:0] {
    TK_IDLE   = 2'd0,
    TK_ACCESS = 2'd1,
    TK_DRIVE  = 2'd2
  } tick_t;

  // Tick that follows the current one, given the sensed read line.
  function automatic tick_t tick_after(input tick_t cur, input logic req);
    case (cur)
      TK_IDLE:   return req ? TK_ACCESS : TK_IDLE;
      TK_ACCESS: return TK_DRIVE;
      default:   return TK_IDLE;
    endcase
  endfunction

  // A preload write lands only when the bus is idle and no read competes.
  function automatic logic write_allowed(input tick_t cur, input logic wr, input logic req);
    return wr && !req && (cur == TK_IDLE);
  endfunction

endpackage

// File: rtl/rdslv_sequencer.sv
module rdslv_sequencer
  import rdslv_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [IDXW-1:0] req_idx,
  output tick_t           tick,
  output logic [IDXW-1:0] held_idx,
  output logic            fetch
);

  tick_t tick_q;
  logic  accept;

  assign accept = (tick_q == TK_IDLE) && rd_req;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= TK_IDLE;
      held_idx <= '0;
    end else begin
      tick_q <= tick_after(tick_q, rd_req);
      if (accept) held_idx <= req_idx;
    end
  end

  assign tick  = tick_q;
  assign fetch = (tick_q == TK_ACCESS);

  assert_accept_starts_access_R1: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick_q == TK_IDLE && rd_req) |=> (tick_q == TK_ACCESS && held_idx == $past(req_idx)))
    else $error("accepted request did not enter access tick");

  assert_address_held_R1: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick_q != TK_IDLE) |=> $stable(held_idx))
    else $error("captured index moved during transfer");

  assert_busy_ignores_req_R5: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick_q == TK_DRIVE && rd_req) |=> (tick_q == TK_IDLE))
    else $error("request during drive tick restarted transfer");

endmodule

// File: rtl/rdslv_array.sv
module rdslv_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_word,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_word
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr_fire) begin
      cells[wr_idx] <= wr_word;
    end
  end

  assign rd_word = cells[rd_idx];

  assert_write_lands_R7: assert property (
    @(negedge clk) disable iff (!rst_n)
    wr_fire |=> (cells[$past(wr_idx)] == $past(wr_word)))
    else $error("write did not update location");

  assert_no_write_keeps_cell_R6: assert property (
    @(negedge clk) disable iff (!rst_n)
    !wr_fire |=> (cells[$past(rd_idx)] == $past(rd_word)))
    else $error("location changed without a write");

endmodule

// File: rtl/rdslv_driver.sv
module rdslv_driver #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe
);

  logic [DW-1:0] hold_q;
  logic          oe_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else if (fetch) begin
      hold_q <= word_in;
      oe_q   <= 1'b1;
    end else begin
      hold_q <= '0;
      oe_q   <= 1'b0;
    end
  end

  assign bus_data = hold_q;
  assign bus_oe   = oe_q;

  assert_released_bus_zero_R4: assert property (
    @(negedge clk) disable iff (!rst_n)
    !oe_q |-> (hold_q == '0))
    else $error("data lines nonzero while released");

  assert_drive_one_tick_R3: assert property (
    @(negedge clk) disable iff (!rst_n)
    oe_q |=> !oe_q)
    else $error("drive lasted more than one tick");

endmodule

// File: rtl/tick_read_slave.sv
module tick_read_slave
  import rdslv_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_req,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          data_oe
);

  localparam int IDXW = $clog2(DEPTH);

  tick_t           tick;
  logic [IDXW-1:0] req_idx;
  logic [IDXW-1:0] held_idx;
  logic            fetch;
  logic            wr_fire;
  logic [DW-1:0]   array_word;

  assign req_idx = addr[IDXW-1:0];
  assign wr_fire = write_allowed(tick, wr_en, rd_req);

  rdslv_sequencer #(.IDXW(IDXW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .req_idx  (req_idx),
    .tick     (tick),
    .held_idx (held_idx),
    .fetch    (fetch)
  );

  rdslv_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_idx  (req_idx),
    .wr_word (wr_data),
    .rd_idx  (held_idx),
    .rd_word (array_word)
  );

  rdslv_driver #(.DW(DW)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch    (fetch),
    .word_in  (array_word),
    .bus_data (rd_data),
    .bus_oe   (data_oe)
  );

  assert_access_quiet_R2: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick == TK_ACCESS) |-> !data_oe)
    else $error("bus driven during access tick");

  assert_access_then_drive_R3: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick == TK_ACCESS) |=> (tick == TK_DRIVE && data_oe))
    else $error("access tick not followed by drive");

  assert_oe_only_in_drive_R4: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick != TK_DRIVE) |-> !data_oe)
    else $error("oe high outside drive tick");

  assert_busy_blocks_write_R8: assert property (
    @(negedge clk) disable iff (!rst_n)
    (tick != TK_IDLE || rd_req) |-> !wr_fire)
    else $error("write accepted while busy or reading");

endmodule

// File: tb/test_tick_read_slave.sv
module test_tick_read_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        data_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tick_read_slave #(.DEPTH(64), .AW(16), .DW(16)) i_tick_read_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_req  (rd_req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .data_oe (data_oe)
  );

  // {address, word}
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'hA5A5}, {16'h0001, 16'h1234}, {16'h003F, 16'hFFFF},
    {16'h0010, 16'h0F0F}, {16'h0022, 16'h8001}, {16'h002A, 16'h7E81},
    {16'h0007, 16'h5555}, {16'h0033, 16'hAAAA}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    step();
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  // Full three-tick read with checks in the access, drive and following tick.
  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string req);
    step();
    addr = a; rd_req = 1'b1;
    step();
    rd_req = 1'b0;
    chk({"R2 oe in access ", req}, {15'd0, data_oe}, 16'd0);
    chk({"R2 data in access ", req}, rd_data, 16'd0);
    step();
    chk({"R3 oe in drive ", req}, {15'd0, data_oe}, 16'd1);
    chk({"R3 data in drive ", req}, rd_data, exp);
    step();
    chk({"R4 oe after drive ", req}, {15'd0, data_oe}, 16'd0);
    chk({"R4 data after drive ", req}, rd_data, 16'd0);
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 oe in reset", {15'd0, data_oe}, 16'd0);
    rst_n = 1'b1;
    step();
    chk("R10 oe after reset", {15'd0, data_oe}, 16'd0);
    chk("R10 data after reset", rd_data, 16'd0);
    rd(16'h0009, 16'h0000, "R10 cleared cell");
    rd(16'h003F, 16'h0000, "R10 cleared top cell");

    // Table: preload then read back (R7, R3)
    for (int i = 0; i < 8; i++) wr(VEC[i][31:16], VEC[i][15:0]);
    for (int i = 0; i < 8; i++) rd(VEC[i][31:16], VEC[i][15:0], "R7 table");

    // R6: repeated reads unchanged
    rd(16'h0001, 16'h1234, "R6 first");
    rd(16'h0001, 16'h1234, "R6 second");

    // R9: aliasing via low index bits
    wr(16'h0045, 16'hBEEF);
    rd(16'h0005, 16'hBEEF, "R9 alias low");
    rd(16'h1005, 16'hBEEF, "R9 alias high");

    // R1 + R5: addr moved and rd_req held during access and drive
    step();
    addr = 16'h0010; rd_req = 1'b1;
    step();
    addr = 16'h0022;
    chk("R2 oe held req", {15'd0, data_oe}, 16'd0);
    step();
    chk("R1 captured addr", rd_data, 16'h0F0F);
    chk("R5 oe drive held req", {15'd0, data_oe}, 16'd1);
    rd_req = 1'b0;
    step();
    chk("R5 no restart tick 1", {15'd0, data_oe}, 16'd0);
    step();
    chk("R5 no restart tick 2", {15'd0, data_oe}, 16'd0);
    step();
    chk("R5 no restart tick 3", {15'd0, data_oe}, 16'd0);

    // R8: write during access tick ignored
    step();
    addr = 16'h0007; rd_req = 1'b1;
    step();
    rd_req = 1'b0; wr_en = 1'b1; wr_data = 16'h0BAD;
    step();
    wr_en = 1'b0;
    chk("R8 read during busy write", rd_data, 16'h5555);
    step();
    rd(16'h0007, 16'h5555, "R8 busy write ignored");

    // R8: write with rd_req on same edge ignored, read proceeds
    step();
    addr = 16'h0033; rd_req = 1'b1; wr_en = 1'b1; wr_data = 16'h1111;
    step();
    rd_req = 1'b0; wr_en = 1'b0;
    step();
    chk("R8 read wins", rd_data, 16'hAAAA);
    step();
    rd(16'h0033, 16'hAAAA, "R8 same-edge write ignored");

    // R7: overwrite at idle
    wr(16'h0033, 16'h2468);
    rd(16'h0033, 16'h2468, "R7 overwrite");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule